// File: doc/BRIEF.md
# Dual-Lane Double-Edge Frame Transmitter

This block is the host-side sender for a two-lane serial link. The receiver samples both data lanes on every transition of a host-generated serial clock. The block accepts one 16-bit word per lane through a valid/ready handshake. Each frame is a burst of eight clock pulses, giving sixteen transitions, and each transition delivers one bit per lane, least significant bit first. A load strobe then closes the frame. While the strobe is high, the serial clock is held idle. A configurable gap follows, and then the next word is accepted.

The serial clock half-period is a count of system clock cycles. A request below the minimum is raised to that minimum, which keeps the serial clock under its rate ceiling; with the default 100 MHz system clock, the floor of 10 cycles gives at most 5 MHz. Within each half-period, the data lanes change only at the midpoint, so every sampling transition sees data that has been stable for about half a half-period on each side. The strobe width and the gap are counted in half-periods. All three settings are captured when a word is accepted.

Lane A bit 0 is the word-type flag for the receiver: 0 means print data and 1 means command. The block sends it as the first bit without changing it.

Top module: `ddr_frame_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `ser_clk`, `ser_load`, `ser_a` and `ser_b` are 0 and `word_ready` is 1.
- R2: Every frame has exactly 16 transitions of `ser_clk` while `ser_load` is low. `ser_clk` idles at 0, so the first transition is rising and the last is falling.
- R3: At the k-th transition of a frame (k = 1..16), `ser_a` carries bit k-1 of `word_a` and `ser_b` carries bit k-1 of `word_b`. Lane A bit 0 (the type flag) therefore goes out first.
- R4: The data lanes never change in the same cycle as a `ser_clk` transition. At every transition, the lanes have held their value for at least floor(H/2) cycles, where H is the effective half-period.
- R5: The effective half-period H is max(`cfg_half`, MIN_HALF) system cycles, and consecutive transitions are exactly H cycles apart. A `cfg_half` below MIN_HALF (default 10) is raised to MIN_HALF.
- R6: `ser_load` rises H cycles after the 16th transition, with `ser_clk` at 0. It stays high for max(`cfg_load`,1)·H cycles, and `ser_clk` does not change while it is high.
- R7: `word_ready` and `frame_done` rise together exactly max(`cfg_gap`,1)·H cycles after `ser_load` falls. `word_ready` stays low from acceptance until then and is never high while `ser_load` is high.
- R8: A word offered while `word_ready` is low is held by the sender and accepted when `word_ready` returns. No word of a back-to-back stream is lost or reordered.
- R9: `cfg_half`, `cfg_load` and `cfg_gap` are sampled only on the accepting cycle. Changing them during a frame has no effect on that frame's timing.
- R10: A reset during a frame abandons it. The outputs return to the R1 state at once, and the next frame after reset is sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | 8 | Requested half-period in system cycles |
| cfg_load | input | 4 | Load strobe width in half-periods (0 acts as 1) |
| cfg_gap | input | 4 | Gap after strobe in half-periods (0 acts as 1) |
| word_valid | input | 1 | Word pair offered |
| word_ready | output | 1 | Sender idle, word pair taken when valid |
| word_a | input | 16 | Lane A word, bit 0 is the type flag |
| word_b | input | 16 | Lane B word |
| ser_clk | output | 1 | Serial clock, both edges sample |
| ser_load | output | 1 | Frame-closing load strobe |
| ser_a | output | 1 | Lane A serial data |
| ser_b | output | 1 | Lane B serial data |
| frame_done | output | 1 | One-cycle pulse when a frame's gap ends |

## Verification
A wrong transition count or slot counter shows up at the next strobe rise: the count of `ser_clk` transitions seen differs from 16, or the strobe is not one half-period after the last transition. A misaligned shift register or lane swap corrupts the words reassembled at that same strobe, within one frame. A divider or phase error shows up at the very next transition as a spacing other than H, or as a lane change too close to it. Strobe-width and gap errors are caught at the strobe fall and at the ready rise of the same frame.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BURST,
    ST_LOAD,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/tx_pace.sv
// Half-period phase counter: emits a tick at the end of each half-period
// and a mid pulse at its centre.
module tx_pace #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clear,
  input  logic [DIV_W-1:0] half,
  output logic             tick,
  output logic             mid
);
  logic [DIV_W-1:0] ph_q, ph_d;
  logic             at_end;

  assign at_end = (ph_q == half - DIV_W'(1));
  assign tick   = en && !clear && at_end;
  assign mid    = en && !clear && (ph_q == (half >> 1) - DIV_W'(1));

  always_comb begin
    ph_d = ph_q;
    if (clear)    ph_d = '0;
    else if (en)  ph_d = at_end ? '0 : ph_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R5: phase never runs past the latched half-period
  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear) |-> (ph_q < half));
endmodule

// File: rtl/tx_lane.sv
// One data lane: parallel load, shift toward bit 0, bit 0 drives the line.
module tx_lane #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              bit_o
);
  logic [WORD_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load)       sreg_d = word;
    else if (shift) sreg_d = {1'b0, sreg_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign bit_o = sreg_q[0];

  // R3: a shift never coincides with a load
  p_load_shift_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/tx_seq.sv
// Frame sequencer: burst of transitions, tail, load strobe, gap.
module tx_seq
  import tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             tick,
  input  logic             mid,
  input  logic [CNT_W-1:0] load_n,
  input  logic [CNT_W-1:0] gap_n,
  output logic             ready,
  output logic             busy,
  output logic             shift,
  output logic             ser_clk,
  output logic             ser_load,
  output logic             done
);
  localparam int EDGE_W = $clog2(WORD_W + 1);
  localparam int SLOT_W = (EDGE_W > CNT_W) ? EDGE_W : CNT_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_W);

  tx_state_e         state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              clk_q, clk_d, load_q, load_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    clk_d   = clk_q;
    load_d  = load_q;
    done_d  = 1'b0;
    shift   = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_BURST;
        slot_d  = '0;
      end
      ST_BURST: begin
        if (mid && slot_q != '0 && slot_q < LAST_SLOT) shift = 1'b1;
        if (tick) begin
          if (slot_q < LAST_SLOT) begin
            clk_d  = ~clk_q;
            slot_d = slot_q + SLOT_W'(1);
          end else begin
            state_d = ST_LOAD;
            load_d  = 1'b1;
            slot_d  = '0;
          end
        end
      end
      ST_LOAD: if (tick) begin
        if (slot_q == SLOT_W'(load_n) - SLOT_W'(1)) begin
          state_d = ST_GAP;
          load_d  = 1'b0;
          slot_d  = '0;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
      ST_GAP: if (tick) begin
        if (slot_q == SLOT_W'(gap_n) - SLOT_W'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          slot_d  = '0;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      clk_q   <= 1'b0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      clk_q   <= clk_d;
      load_q  <= load_d;
      done_q  <= done_d;
    end
  end

  assign ready    = (state_q == ST_IDLE);
  assign busy     = !ready;
  assign ser_clk  = clk_q;
  assign ser_load = load_q;
  assign done     = done_q;

  // R6: serial clock parked low and frozen during the strobe
  p_load_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (!clk_q && $stable(clk_q)));
  // R7: never ready while the strobe is up
  p_ready_not_loading_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!load_q && !clk_q));
  // R2: slot counter never exceeds the tail slot
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST) |-> (slot_q <= LAST_SLOT));
endmodule

// File: rtl/ddr_frame_tx.sv
module ddr_frame_tx #(
  parameter int WORD_W   = 16,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 4,
  parameter int MIN_HALF = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_load,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              ser_clk,
  output logic              ser_load,
  output logic              ser_a,
  output logic              ser_b,
  output logic              frame_done
);
  localparam int NUM_LANES = 2;
  localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(MIN_HALF);

  logic             accept, busy, tick, mid, shift;
  logic [DIV_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] load_q, load_d, gap_q, gap_d;
  logic [WORD_W-1:0] lane_word [NUM_LANES];
  logic [NUM_LANES-1:0] lane_bit;

  assign accept = word_valid && word_ready;

  // configuration captured on acceptance, clamped to legal values
  always_comb begin
    half_d = half_q;
    load_d = load_q;
    gap_d  = gap_q;
    if (accept) begin
      half_d = (cfg_half < HALF_FLOOR) ? HALF_FLOOR : cfg_half;
      load_d = (cfg_load == '0) ? CNT_W'(1) : cfg_load;
      gap_d  = (cfg_gap  == '0) ? CNT_W'(1) : cfg_gap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_FLOOR;
      load_q <= CNT_W'(1);
      gap_q  <= CNT_W'(1);
    end else begin
      half_q <= half_d;
      load_q <= load_d;
      gap_q  <= gap_d;
    end
  end

  tx_pace #(.DIV_W(DIV_W)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy),
    .clear (accept),
    .half  (half_q),
    .tick  (tick),
    .mid   (mid)
  );

  tx_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .tick     (tick),
    .mid      (mid),
    .load_n   (load_q),
    .gap_n    (gap_q),
    .ready    (word_ready),
    .busy     (busy),
    .shift    (shift),
    .ser_clk  (ser_clk),
    .ser_load (ser_load),
    .done     (frame_done)
  );

  assign lane_word[0] = word_a;
  assign lane_word[1] = word_b;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    tx_lane #(.WORD_W(WORD_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .shift (shift),
      .word  (lane_word[g]),
      .bit_o (lane_bit[g])
    );
  end

  assign ser_a = lane_bit[0];
  assign ser_b = lane_bit[1];

  // R4: lanes hold still on every serial clock transition
  p_lane_still_at_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_clk) |-> ($stable(ser_a) && $stable(ser_b)));
  // R9: captured half-period stays legal
  p_half_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_q >= HALF_FLOOR);
endmodule

// File: tb/sim_ddr_frame_tx.sv
module sim_ddr_frame_tx;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    int h;
    int l;
    int g;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_half = 8'd10;
  logic [3:0] cfg_load = 4'd1;
  logic [3:0] cfg_gap  = 4'd1;
  logic word_valid = 1'b0;
  logic [W-1:0] word_a = '0;
  logic [W-1:0] word_b = '0;
  logic word_ready, ser_clk, ser_load, ser_a, ser_b, frame_done;

  always #5 clk = ~clk;

  ddr_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_load(cfg_load),
    .cfg_gap(cfg_gap), .word_valid(word_valid), .word_ready(word_ready),
    .word_a(word_a), .word_b(word_b), .ser_clk(ser_clk), .ser_load(ser_load),
    .ser_a(ser_a), .ser_b(ser_b), .frame_done(frame_done)
  );

  int total = 0;
  int bad = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  exp_t q[$];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  // driver: offer a word pair, push the expectation on acceptance
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input int half, input int ld, input int gp);
    exp_t e;
    @(negedge clk);
    word_a = a; word_b = b;
    cfg_half = 8'(half); cfg_load = 4'(ld); cfg_gap = 4'(gp);
    word_valid = 1'b1;
    while (!word_ready) @(negedge clk);
    e.a = a; e.b = b;
    e.h = (half < 10) ? 10 : half;
    e.l = (ld == 0) ? 1 : ld;
    e.g = (gp == 0) ? 1 : gp;
    q.push_back(e);
    frames_sent++;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // monitor
  int cyc = 0, last_edge = 0, last_chg = 0, rise_t = 0, fall_t = 0, edges = 0;
  logic pclk = 1'b0, pload = 1'b0, pready = 1'b1, pa = 1'b0, pb = 1'b0;
  logic [W-1:0] cap_a, cap_b;
  exp_t cur;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      edges = 0;
      q.delete();
    end else begin
      if ({ser_a, ser_b} != {pa, pb}) last_chg = cyc;
      if (ser_clk != pclk) begin
        if (ser_load) begin
          chk("R6 clock moved during strobe", 1, 0);
        end else begin
          if (edges == 0) begin
            if (q.size() == 0) chk("R8 frame with no offered word", 1, 0);
            else cur = q.pop_front();
            chk("R2 first transition rising", int'(ser_clk), 1);
          end else begin
            chk("R5/R9 transition spacing", cyc - last_edge, cur.h);
          end
          chk_ge("R4 lane setup before transition", cyc - last_chg, cur.h / 2);
          if (edges < W) begin
            cap_a[edges] = ser_a;
            cap_b[edges] = ser_b;
          end
          edges++;
          last_edge = cyc;
        end
      end
      if (ser_load && !pload) begin
        chk("R2 transitions per frame", edges, W);
        chk("R6 clock low at strobe", int'(ser_clk), 0);
        chk("R6 strobe delay after last transition", cyc - last_edge, cur.h);
        chk("R3 lane A word", int'(cap_a), int'(cur.a));
        chk("R3 lane B word", int'(cap_b), int'(cur.b));
        rise_t = cyc;
        edges = 0;
      end
      if (!ser_load && pload) begin
        chk("R6 strobe width", cyc - rise_t, cur.l * cur.h);
        fall_t = cyc;
      end
      if (word_ready && ser_load) chk("R7 ready during strobe", 1, 0);
      if (word_ready && !pready) begin
        chk("R7 gap before ready", cyc - fall_t, cur.g * cur.h);
        chk("R7 done with ready", int'(frame_done), 1);
        frames_seen++;
      end
    end
    pclk = ser_clk; pload = ser_load; pready = word_ready; pa = ser_a; pb = ser_b;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", frames_seen, frames_sent);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 clock in reset", int'(ser_clk), 0);
    chk("R1 strobe in reset", int'(ser_load), 0);
    chk("R1 lanes in reset", int'({ser_a, ser_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(word_ready), 1);
    chk("R1 clock after reset", int'(ser_clk), 0);

    send(16'hA5C3, 16'h0F01, 10, 1, 1);
    // R5 clamp and zero settings
    send(16'h0001, 16'hFFFF, 3, 0, 0);
    // R9: settings changed mid-frame must not disturb this frame
    send(16'h8000, 16'h7FFE, 13, 2, 3);
    repeat (20) @(negedge clk);
    cfg_half = 8'd40; cfg_load = 4'd9; cfg_gap = 4'd9;
    // R8 back-to-back stream, words offered while ready is low
    send(16'h1234, 16'hFEDC, 10, 1, 1);
    send(16'h5555, 16'hAAAA, 10, 1, 1);
    send(16'h0000, 16'h8001, 11, 1, 2);
    while (frames_seen != frames_sent) @(negedge clk);

    // R10 reset mid-frame
    send(16'hFFFF, 16'hFFFF, 10, 1, 1);
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    frames_sent--;
    @(negedge clk);
    chk("R10 clock cleared", int'(ser_clk), 0);
    chk("R10 lanes cleared", int'({ser_a, ser_b}), 0);
    chk("R10 ready in reset", int'(word_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    send(16'hC001, 16'h0BAD, 20, 3, 2);
    while (frames_seen != frames_sent) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R8 frames delivered", frames_seen, frames_sent);
    chk("R8 no leftover expectations", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule